// File: doc/BRIEF.md
# Slave-Mode Row Readout Sequencer

This block is the digital readout controller of an image sensor whose row timing is paced entirely by an outside controller. A one-cycle pulse on `row_go` launches a row conversion of fixed length. The length does not depend on the programmed window. While the conversion runs, the converter model writes its samples into the fill bank of a two-bank row store. When the conversion finishes, the two banks swap roles, so the freshly converted row becomes readable.

Readout is gated by the active-low level `shift_n`. While it is low, a column counter steps once per clock through the readout bank. Pixels come out on the falling clock edge, three and a half clocks after the edge that first saw `shift_n` low. A valid flag marks the columns that lie inside the programmed window. Window limits and a clear command are written through a simple register port. A frame-sync line held low for two clocks also clears both counters.

Top module: `slave_readout_seq`

## Requirements
- R1: An accepted rising edge of `row_go` moves `row_idx` to `row_first` when `row_idx` is below `row_first` or at or above `row_last`, and otherwise to `row_idx + 1`. Repeated rows therefore wrap from the last row of the window back to the first.
- R2: After an accepted `row_go` edge, `seq_busy` is high for exactly SEQ_LEN (default 671) clock cycles, whatever the window.
- R3: The column counter is zero on every edge that samples `shift_n` high. On each edge that samples it low, the current column is read and the counter then steps by one, starting at column 0.
- R4: Once the column counter reaches `col_last`, it stays there while `shift_n` stays low. That column is then output repeatedly.
- R5: The column read at the edge that samples `shift_n` low appears on `pix_data` at the falling edge 3.5 clocks later.
- R6: `pix_valid` is 1 only for columns c with `col_first` <= c <= `col_last`. `pix_data` is 0 whenever `pix_valid` is 0.
- R7: `smp_we` writes into the fill bank. The banks swap when the conversion ends, so readout never returns data written during the current conversion.
- R8: A rising edge of `row_go` while `seq_busy` is high is ignored (`row_idx` unchanged, no new conversion). It sets `overrun`, which stays set until reset.
- R9: Register map (`reg_addr`): 0 = row_first, 1 = row_last, 2 = col_first, 3 = col_last, 4 = clear. A write to address 4 with `reg_wdata[0]`=1 zeroes the row and column counters.
- R10: `fsync_n` sampled low on two consecutive edges zeroes both counters. A single low sample has no effect.
- R11: While `shift_n` is held high, outputs go quiet (`pix_valid`=0, `pix_data`=0) once the pipeline drains. This gives horizontal blanking.
- R12: After reset, `row_idx`=0, `seq_busy`=0, `overrun`=0, `pix_valid`=0 and `pix_data`=0. The window defaults to the full array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_go | input | 1 | Row start pulse, one clock wide |
| shift_n | input | 1 | Active-low readout enable |
| fsync_n | input | 1 | Active-low frame sync |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| smp_we | input | 1 | Converter sample write strobe |
| smp_addr | input | COL_W | Column of the sample |
| smp_data | input | DATA_W | Sample value |
| pix_data | output | DATA_W | Pixel output, launched on the falling edge |
| pix_valid | output | 1 | Pixel lies inside the column window |
| seq_busy | output | 1 | Row conversion in progress |
| overrun | output | 1 | Sticky flag: start pulse arrived while busy |
| row_idx | output | ROW_W | Current row counter |

## Verification
The assertions assume the window registers are left alone in cycles where a row starts or a column is being read. They also assume `row_first` <= `row_last`, so each property compares a counter against limits that were stable across the edge. The stimulus writes the window once, before any row activity, and changes only the start, readout, sample and sync lines afterwards. `row_go` is driven as one-clock pulses separated by low cycles, so every rising edge the checks rely on is clean.

// File: rtl/rdo_pkg.sv
// Shared register addresses for the slave-mode readout sequencer.
package rdo_pkg;
    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] A_ROW_FIRST = 3'd0;
    localparam logic [REG_AW-1:0] A_ROW_LAST  = 3'd1;
    localparam logic [REG_AW-1:0] A_COL_FIRST = 3'd2;
    localparam logic [REG_AW-1:0] A_COL_LAST  = 3'd3;
    localparam logic [REG_AW-1:0] A_CLEAR     = 3'd4;
endpackage

// File: rtl/rdo_cfg.sv
// Window registers and clear generation.
// Holds the row and column window limits. It issues a one-cycle clear
// when software writes the clear bit or when frame sync is low on two
// consecutive edges. Assumes writes do not overlap row activity.
module rdo_cfg
    import rdo_pkg::*;
#(
    parameter int ROWS  = 480,
    parameter int NCOLS = 640,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(NCOLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              fsync_n,
    output logic [ROW_W-1:0]  row_first,
    output logic [ROW_W-1:0]  row_last,
    output logic [COL_W-1:0]  col_first,
    output logic [COL_W-1:0]  col_last,
    output logic              clr
);
    logic fs_q;

    // Register file: window limits, full array after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_first <= '0;
            row_last  <= ROW_W'(ROWS - 1);
            col_first <= '0;
            col_last  <= COL_W'(NCOLS - 1);
        end else if (reg_we) begin
            case (reg_addr)
                A_ROW_FIRST: row_first <= reg_wdata[ROW_W-1:0];
                A_ROW_LAST:  row_last  <= reg_wdata[ROW_W-1:0];
                A_COL_FIRST: col_first <= reg_wdata[COL_W-1:0];
                A_COL_LAST:  col_last  <= reg_wdata[COL_W-1:0];
                default: ;
            endcase
        end
    end

    // Previous frame-sync sample for two-low detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= 1'b1;
        else        fs_q <= fsync_n;
    end

    // Clear request from either source.
    always_comb clr = (reg_we && reg_addr == A_CLEAR && reg_wdata[0]) || (!fs_q && !fsync_n);
endmodule

// File: rtl/rdo_row_seq.sv
// Row start detection, fixed-length conversion sequencer, row counter,
// bank role and overrun flag.
// Assumes row_go pulses are one clock wide; edges while busy are dropped.
module rdo_row_seq #(
    parameter int ROWS    = 480,
    parameter int SEQ_LEN = 671,
    parameter int ROW_W   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_go,
    input  logic             clr,
    input  logic [ROW_W-1:0] row_first,
    input  logic [ROW_W-1:0] row_last,
    output logic [ROW_W-1:0] row_idx,
    output logic             busy,
    output logic             overrun,
    output logic             rd_bank
);
    localparam int CNT_W = $clog2(SEQ_LEN);

    logic             go_q;
    logic             rise;
    logic             take;
    logic [CNT_W-1:0] left;

    // Start pulse history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= row_go;
    end

    always_comb begin
        rise = row_go && !go_q;
        take = rise && !busy;
    end

    // Conversion timer; swaps bank roles on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            left    <= '0;
            rd_bank <= 1'b0;
        end else if (take) begin
            busy <= 1'b1;
            left <= CNT_W'(SEQ_LEN - 1);
        end else if (busy) begin
            if (left == '0) begin
                busy    <= 1'b0;
                rd_bank <= !rd_bank;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    // Windowed row counter with wrap to the first row.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) row_idx <= '0;
        else if (take) begin
            if (row_idx < row_first || row_idx >= row_last) row_idx <= row_first;
            else                                            row_idx <= row_idx + 1'b1;
        end
    end

    // Sticky overrun on a start edge during a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)             overrun <= 1'b0;
        else if (rise && busy)  overrun <= 1'b1;
    end

    a_r1_row_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr && row_first <= row_last) |=> (row_idx >= row_first && row_idx <= row_last));
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy && !clr) |=> $stable(row_idx));
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    a_r2_busy_holds_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);
endmodule

// File: rtl/rdo_col_rd.sv
// Column counter, two-bank row store and output pipeline.
// Samples are written to the bank not being read. The readout path has
// PIPE_POS rising-edge stages followed by a falling-edge output register.
// Assumes col_first <= col_last and window stable while reading.
module rdo_col_rd #(
    parameter int NCOLS    = 640,
    parameter int DATA_W   = 10,
    parameter int PIPE_POS = 4,
    parameter int COL_W    = $clog2(NCOLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_n,
    input  logic              clr,
    input  logic [COL_W-1:0]  col_first,
    input  logic [COL_W-1:0]  col_last,
    input  logic              rd_bank,
    input  logic              smp_we,
    input  logic [COL_W-1:0]  smp_addr,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] pix_data,
    output logic              pix_valid
);
    localparam int DLY = PIPE_POS - 2;

    logic [DATA_W-1:0] mem [2][NCOLS];
    logic [COL_W-1:0]  col_cnt;
    logic              s1_act, s1_in;
    logic [COL_W-1:0]  s1_addr;
    logic              dl_v [DLY+1];
    logic [DATA_W-1:0] dl_d [DLY+1];

    // Converter writes land in the fill bank.
    always_ff @(posedge clk) begin
        if (smp_we && int'(smp_addr) < NCOLS) mem[!rd_bank][smp_addr] <= smp_data;
    end

    // Column counter: zero while disabled, capped at the last column.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || shift_n) col_cnt <= '0;
        else if (col_cnt != col_last && int'(col_cnt) < NCOLS - 1) col_cnt <= col_cnt + 1'b1;
    end

    // Stage 1: capture column and window membership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_act  <= 1'b0;
            s1_in   <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_act  <= !shift_n;
            s1_in   <= (col_cnt >= col_first) && (col_cnt <= col_last);
            s1_addr <= col_cnt;
        end
    end

    // Stage 2: read the readout bank, blank outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_v[0] <= 1'b0;
            dl_d[0] <= '0;
        end else begin
            dl_v[0] <= s1_act && s1_in;
            dl_d[0] <= (s1_act && s1_in && int'(s1_addr) < NCOLS) ? mem[rd_bank][s1_addr] : '0;
        end
    end

    // Delay stages up to the falling-edge launch.
    for (genvar g = 1; g <= DLY; g++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dl_v[g] <= 1'b0;
                dl_d[g] <= '0;
            end else begin
                dl_v[g] <= dl_v[g-1];
                dl_d[g] <= dl_d[g-1];
            end
        end
    end

    // Output launch on the falling edge (half-cycle final stage).
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_data  <= '0;
        end else begin
            pix_valid <= dl_v[DLY];
            pix_data  <= dl_d[DLY];
        end
    end

    a_r3_col_zero_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        shift_n |=> col_cnt == '0);
    a_r4_col_held_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_n && !clr && col_cnt == col_last) |=> col_cnt == col_last);
    a_r6_blank_outside: assert property (@(negedge clk) disable iff (!rst_n)
        !pix_valid |-> pix_data == '0);
endmodule

// File: rtl/slave_readout_seq.sv
// Top of the slave-mode readout sequencer: register port, row sequencer
// and column readout. Assumes one-clock row_go pulses and a quiet window
// configuration while rows are converted or read.
module slave_readout_seq
    import rdo_pkg::*;
#(
    parameter int ROWS     = 480,
    parameter int NCOLS    = 640,
    parameter int DATA_W   = 10,
    parameter int SEQ_LEN  = 671,
    parameter int PIPE_POS = 4,
    parameter int ROW_W    = $clog2(ROWS),
    parameter int COL_W    = $clog2(NCOLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_go,
    input  logic              shift_n,
    input  logic              fsync_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              smp_we,
    input  logic [COL_W-1:0]  smp_addr,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] pix_data,
    output logic              pix_valid,
    output logic              seq_busy,
    output logic              overrun,
    output logic [ROW_W-1:0]  row_idx
);
    logic [ROW_W-1:0] row_first, row_last;
    logic [COL_W-1:0] col_first, col_last;
    logic             clr, rd_bank;

    rdo_cfg #(.ROWS(ROWS), .NCOLS(NCOLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .fsync_n(fsync_n), .row_first(row_first),
        .row_last(row_last), .col_first(col_first), .col_last(col_last), .clr(clr)
    );

    rdo_row_seq #(.ROWS(ROWS), .SEQ_LEN(SEQ_LEN), .ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .row_go(row_go), .clr(clr),
        .row_first(row_first), .row_last(row_last), .row_idx(row_idx),
        .busy(seq_busy), .overrun(overrun), .rd_bank(rd_bank)
    );

    rdo_col_rd #(.NCOLS(NCOLS), .DATA_W(DATA_W), .PIPE_POS(PIPE_POS), .COL_W(COL_W)) u_col (
        .clk(clk), .rst_n(rst_n), .shift_n(shift_n), .clr(clr),
        .col_first(col_first), .col_last(col_last), .rd_bank(rd_bank),
        .smp_we(smp_we), .smp_addr(smp_addr), .smp_data(smp_data),
        .pix_data(pix_data), .pix_valid(pix_valid)
    );
endmodule

// File: tb/slave_readout_seq_tb.sv
`timescale 1ns/1ps
module slave_readout_seq_tb;
    localparam int SEQ = 671;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_go = 1'b0, shift_n = 1'b1, fsync_n = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic       smp_we = 1'b0;
    logic [9:0] smp_addr = '0;
    logic [9:0] smp_data = '0;
    logic [9:0] pix_data;
    logic       pix_valid, seq_busy, overrun;
    logic [8:0] row_idx;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Readout expectation per column step: {valid, column}; window 2..5, 10 reads then idle.
    localparam logic [3:0] EXP_TAB [11] = '{
        4'b0_000, 4'b0_001, 4'b1_010, 4'b1_011, 4'b1_100, 4'b1_101,
        4'b1_101, 4'b1_101, 4'b1_101, 4'b1_101, 4'b0_000 };

    slave_readout_seq u_dut (
        .clk(clk), .rst_n(rst_n), .row_go(row_go), .shift_n(shift_n), .fsync_n(fsync_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .smp_we(smp_we),
        .smp_addr(smp_addr), .smp_data(smp_data), .pix_data(pix_data), .pix_valid(pix_valid),
        .seq_busy(seq_busy), .overrun(overrun), .row_idx(row_idx)
    );

    always #5 clk = !clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #2 reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2 reg_we = 1'b0;
    endtask

    task automatic pulse_row();
        @(posedge clk); #2 row_go = 1'b1;
        @(posedge clk); #2 row_go = 1'b0;
    endtask

    task automatic fill_row(input int base);
        for (int a = 0; a < 8; a++) begin
            @(posedge clk); #2 smp_we = 1'b1; smp_addr = 10'(a); smp_data = 10'(base + a);
        end
        @(posedge clk); #2 smp_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (seq_busy) begin @(posedge clk); #2; end
    endtask

    // Walk the expectation table: column read at edge k shows at sample after edge k+3.
    task automatic readout(input int base, input string tag);
        @(posedge clk); #2 shift_n = 1'b0;
        for (int j = 0; j <= 13; j++) begin
            @(posedge clk); #2;
            if (j == 9) shift_n = 1'b1;
            #6;
            if (j >= 3) begin
                check({tag, " valid"}, int'(pix_valid), int'(EXP_TAB[j-3][3]));
                check({tag, " data"}, int'(pix_data),
                      EXP_TAB[j-3][3] ? base + int'(EXP_TAB[j-3][2:0]) : 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #6;
        // R12 reset state
        check("R12 row_idx", int'(row_idx), 0);
        check("R12 busy", int'(seq_busy), 0);
        check("R12 overrun", int'(overrun), 0);
        check("R12 valid", int'(pix_valid), 0);

        reg_write(3'd0, 16'd3);
        reg_write(3'd1, 16'd4);
        reg_write(3'd2, 16'd2);
        reg_write(3'd3, 16'd5);

        // R7 fill bank then R1 first row, R2 busy length
        fill_row(100);
        pulse_row();
        begin
            int cnt = 0;
            forever begin
                #6;
                if (!seq_busy) break;
                cnt++;
                @(posedge clk); #2;
            end
            check("R2 busy cycles", cnt, SEQ);
        end
        check("R1 first row", int'(row_idx), 3);
        // R3 R4 R5 R6 R11 readout of converted row
        readout(100, "R5/R6 row A");

        // Pipelined: R7 readout during conversion sees the previous row
        pulse_row();
        #6 check("R1 advance", int'(row_idx), 4);
        fill_row(200);
        readout(100, "R7 pipelined");
        // R8 start during busy
        pulse_row();
        #6 check("R8 overrun set", int'(overrun), 1);
        check("R8 row unchanged", int'(row_idx), 4);
        wait_idle();
        // R3 counter restarted at 0 after high level
        readout(200, "R3/R7 row B");

        pulse_row();
        #6 check("R1 wrap", int'(row_idx), 3);
        wait_idle();

        // R9 register clear
        reg_write(3'd4, 16'd1);
        #6 check("R9 clear", int'(row_idx), 0);
        pulse_row();
        #6 check("R1 after clear", int'(row_idx), 3);

        // R10 single low sample ignored, two lows clear
        @(posedge clk); #2 fsync_n = 1'b0;
        @(posedge clk); #2 fsync_n = 1'b1;
        #6 check("R10 one low ignored", int'(row_idx), 3);
        @(posedge clk); #2 fsync_n = 1'b0;
        @(posedge clk); @(posedge clk); #2 fsync_n = 1'b1;
        #6 check("R10 two lows clear", int'(row_idx), 0);
        check("R8 overrun sticky", int'(overrun), 1);
        // R11 blanking while shift_n held high
        repeat (6) @(posedge clk);
        #8 check("R11 blank valid", int'(pix_valid), 0);
        check("R11 blank data", int'(pix_data), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule